// File: doc/BRIEF.md
# Energize-then-Chop Channel Sequencer

This block sequences the gate-enable bits of eight low-side channels that share one 8-bit configuration byte. When a channel's command bit goes high, the channel is driven fully on for a programmable energizing interval. It then either drops into pulse-width chopping at a programmable eighth-step duty or stays fully on, depending on a timer-enable bit. The energizing interval follows a fixed non-linear table of millisecond values. A one-cycle chop-start pulse can end the energizing interval early. Chopping frequency depends on the duty: the lowest duty chops slowest and duties above one quarter chop fastest.

Each channel keeps its own phase and counter. A per-channel force-off input turns a channel off at once and keeps it off until its command bit is taken low and raised again. All millisecond and kilohertz figures are derived from the clock-frequency parameter. That parameter must be a multiple of 400 kHz so that every chopping period divides into eighths.

Top module: `hold_profile_seq`

## Requirements
- R1: While reset is asserted, and after reset with all command bits low, every gate-enable bit is 0.
- R2: The energizing code is cfg[3:0]. Codes 0 to 15 select 0, 3, 5, 10, 15, 20, 30, 50, 80, 110, 140, 170, 200, 230, 260 and 300 ms, each counted as ms*CLK_HZ/1000 clocks. A channel is fully on for exactly that many cycles, starting the cycle after the clock edge that samples its command bit rising.
- R3: The duty code is cfg[6:4] = n. While chopping, the gate is on for the first n/8 of each period and off for the rest. Code 000 keeps the gate off.
- R4: The chopping period is CLK_HZ/12500 clocks for duty code 001, CLK_HZ/25000 for 010 and CLK_HZ/50000 for codes 011 to 111. Each period starts at the cycle the channel enters chopping.
- R5: With cfg[7] = 1, a channel chops after its energizing interval ends. With code 0 it chops from its first cycle.
- R6: With cfg[7] = 0, a channel stays fully on after its energizing interval ends, for as long as its command bit stays high.
- R7: A chop_start pulse that arrives while a channel is energizing puts that channel into chopping on the next cycle, with a fresh period.
- R8: With cfg[7] = 0, a chop_start pulse that arrives after the energizing interval has ended has no effect; the gate stays on.
- R9: A command bit that is low forces the gate off from the next cycle. Raising the bit again restarts the full energizing interval.
- R10: While force_off of a channel is high, its gate is off. After force_off is released the gate stays off until the command bit falls and rises again.
- R11: Channels run independently: a channel's timing is unaffected by the state of the other channels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_on | input | NCH | Per-channel on command |
| cfg | input | 8 | Shared config: [7] timer enable, [6:4] duty code, [3:0] energizing code |
| chop_start | input | 1 | Single-cycle request to end energizing and begin chopping |
| force_off | input | NCH | Per-channel protective shutdown |
| gate_en | output | NCH | Per-channel gate enable |

## Verification
Every result is due one clock edge after the input that causes it. A rising command bit, a chop_start pulse, a falling command bit or a force_off all change the gate in the cycle after the edge that samples them. From there the energizing interval lasts exactly its table count of cycles, and chopping begins at the start of a period. The bench drives inputs on the falling edge, numbers the cycles that follow from 1, and compares each cycle's gate bit with a waveform computed from the interval length, period and on-time of the requirement. All samples are taken on falling edges, so no check races the updating edge.

// File: rtl/hold_profile_seq.sv
module hold_profile_seq #(
  parameter int NCH    = 8,
  parameter int CLK_HZ = 100_000_000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cmd_on,
  input  logic [7:0]     cfg,
  input  logic           chop_start,
  input  logic [NCH-1:0] force_off,
  output logic [NCH-1:0] gate_en
);

  localparam int TPM  = CLK_HZ / 1000;
  localparam int BASE = CLK_HZ / 50000;
  localparam int CW   = $clog2(300 * TPM + 4 * BASE + 1);

  typedef enum logic [1:0] {P_OFF, P_ENER, P_CHOP, P_FULL} phase_t;

  function automatic int ms_of(input logic [3:0] c);
    case (c)
      4'd0:    return 0;
      4'd1:    return 3;
      4'd2:    return 5;
      4'd3:    return 10;
      4'd4:    return 15;
      4'd5:    return 20;
      4'd6:    return 30;
      4'd7:    return 50;
      4'd15:   return 300;
      default: return 80 + (int'(c) - 8) * 30;
    endcase
  endfunction

  wire       tmr_en = cfg[7];
  wire [2:0] duty   = cfg[6:4];

  logic [CW-1:0] limit, period, on_len;

  always_comb begin
    limit = CW'(ms_of(cfg[3:0]) * TPM);
    if (duty == 3'd1)      period = CW'(4 * BASE);
    else if (duty == 3'd2) period = CW'(2 * BASE);
    else                   period = CW'(BASE);
    on_len = CW'((32'(period) * 32'(duty)) >> 3);
  end

  logic [NCH-1:0] cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_on;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    phase_t        ph;
    logic [CW-1:0] cnt;
    logic          start;

    assign start = cmd_on[g] & ~cmd_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ph  <= P_OFF;
        cnt <= '0;
      end else if (!cmd_on[g] || force_off[g]) begin
        ph  <= P_OFF;
        cnt <= '0;
      end else if (start) begin
        cnt <= '0;
        if (limit == '0) ph <= tmr_en ? P_CHOP : P_FULL;
        else             ph <= P_ENER;
      end else begin
        case (ph)
          P_ENER: begin
            if (chop_start) begin
              ph  <= P_CHOP;
              cnt <= '0;
            end else if (cnt + 1'b1 >= limit) begin
              ph  <= tmr_en ? P_CHOP : P_FULL;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          P_CHOP:  cnt <= (cnt + 1'b1 >= period) ? '0 : cnt + 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end

    assign gate_en[g] = ~force_off[g] &
                        ((ph == P_ENER) | (ph == P_FULL) |
                         ((ph == P_CHOP) & (cnt < on_len)));

    // R9
    cmd_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_on[g] |=> !gate_en[g]);

    // R10
    force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (force_off[g] && cmd_on[g]) |=> !gate_en[g]);

    // R2
    start_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !tmr_en && !force_off[g]) |=> (gate_en[g] || force_off[g]));

    // R8
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == P_FULL && cmd_on[g] && !force_off[g]) |=> (ph == P_FULL));
  end

endmodule

// File: tb/test_hold_profile_seq.sv
module test_hold_profile_seq;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] cmd_on = '0;
  logic [7:0]     cfg = '0;
  logic           chop_start = 1'b0;
  logic [NCH-1:0] force_off = '0;
  logic [NCH-1:0] gate_en;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  always #4 clk = ~clk;

  hold_profile_seq #(.NCH(NCH), .CLK_HZ(800_000)) i_hold_profile_seq (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .cfg(cfg),
    .chop_start(chop_start), .force_off(force_off), .gate_en(gate_en));

  // {cfg, energize cycles, period, on cycles}; 800 clocks per ms, base period 16
  localparam logic [63:0] VEC [8] = '{
    {8'hB1, 24'd2400,  16'd16, 16'd6},   // R2 R3 R5: 3 ms then 3/8
    {8'h90, 24'd0,     16'd64, 16'd8},   // R4 R5: 12.5 kHz at 1/8
    {8'hA0, 24'd0,     16'd32, 16'd8},   // R4: 25 kHz at 2/8
    {8'hF0, 24'd0,     16'd16, 16'd14},  // R3 R4: 7/8
    {8'h82, 24'd4000,  16'd16, 16'd0},   // R3: 5 ms then off
    {8'h53, 24'd8000,  16'd1,  16'd1},   // R6: 10 ms then stays on
    {8'hC4, 24'd12000, 16'd16, 16'd8},   // R2: 15 ms then 4/8
    {8'hE8, 24'd64000, 16'd16, 16'd12}   // R2: 80 ms then 6/8
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_wave(input int ch, input int e, input int p, input int on,
                          input int k0, input int n, input string req);
    int bad = 0;
    int ba = 0;
    int be = 0;
    for (int k = k0; k <= n; k++) begin
      logic [NCH-1:0] expv;
      @(negedge clk);
      expv = '0;
      expv[ch] = (k <= e) ? 1'b1 : (((k - e - 1) % p) < on);
      if (gate_en !== expv && bad == 0) begin
        bad = k;
        ba = int'(gate_en);
        be = int'(expv);
      end
    end
    chk(bad == 0, req, ba, be);
  endtask

  task automatic settle_off;
    cmd_on = '0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    cmd_on = '1;
    repeat (3) @(negedge clk);
    chk(gate_en == '0, "R1 during reset", int'(gate_en), 0);
    cmd_on = '0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(gate_en == '0, "R1 after reset", int'(gate_en), 0);

    for (int v = 0; v < 8; v++) begin
      int e, p, on;
      settle_off();
      cfg = VEC[v][63:56];
      e   = int'(VEC[v][55:32]);
      p   = int'(VEC[v][31:16]);
      on  = int'(VEC[v][15:0]);
      cmd_on[0] = 1'b1;
      run_wave(0, e, p, on, 1, e + 3 * p + 8, "R2 R3 R4 R5 R6 vector");
    end

    // R7: chop_start cuts energizing short
    settle_off();
    cfg = 8'h32;
    cmd_on[0] = 1'b1;
    run_wave(0, 100, 1, 1, 1, 100, "R7 energizing before pulse");
    chop_start = 1'b1;
    @(negedge clk);
    chop_start = 1'b0;
    chk(gate_en == 8'h01, "R7 first chop cycle", int'(gate_en), 1);
    run_wave(0, 0, 16, 6, 2, 48, "R7 chopping after pulse");

    // R6 R8: late chop_start ignored with timer disabled
    settle_off();
    cfg = 8'h31;
    cmd_on[0] = 1'b1;
    run_wave(0, 2400, 1, 1, 1, 2500, "R6 full on past interval");
    chop_start = 1'b1;
    @(negedge clk);
    chop_start = 1'b0;
    chk(gate_en == 8'h01, "R8 pulse after expiry", int'(gate_en), 1);
    run_wave(0, 0, 1, 1, 2, 40, "R8 stays on");

    // R9: off next cycle, restart of full interval
    cmd_on[0] = 1'b0;
    @(negedge clk);
    chk(gate_en == 8'h00, "R9 off after command low", int'(gate_en), 0);
    cfg = 8'hB1;
    cmd_on[0] = 1'b1;
    run_wave(0, 2400, 16, 6, 1, 1000, "R9 partial interval");
    cmd_on[0] = 1'b0;
    @(negedge clk);
    chk(gate_en == 8'h00, "R9 off mid interval", int'(gate_en), 0);
    cmd_on[0] = 1'b1;
    run_wave(0, 2400, 16, 6, 1, 2448, "R9 restarted interval");

    // R10: force_off latches channel off
    settle_off();
    cfg = 8'hB0;
    cmd_on[0] = 1'b1;
    run_wave(0, 0, 16, 6, 1, 20, "R5 chop from start");
    force_off[0] = 1'b1;
    @(negedge clk);
    chk(gate_en == 8'h00, "R10 forced off", int'(gate_en), 0);
    force_off[0] = 1'b0;
    run_wave(0, 0, 1, 0, 1, 50, "R10 stays off after release");
    settle_off();
    cmd_on[0] = 1'b1;
    run_wave(0, 0, 16, 6, 1, 48, "R10 rearm by command edge");

    // R11: independent channels
    settle_off();
    cfg = 8'h00;
    cmd_on[0] = 1'b1;
    repeat (10) @(negedge clk);
    cmd_on[5] = 1'b1;
    repeat (10) @(negedge clk);
    chk(gate_en == 8'h21, "R11 two channels on", int'(gate_en), 33);
    cmd_on[0] = 1'b0;
    @(negedge clk);
    chk(gate_en == 8'h20, "R11 other channel kept", int'(gate_en), 32);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule